// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MII management bus (Clause 22 framing). Software programs a 32-bit register window: one register carries the PHY address, the PHY register number and the direction; another carries the 16-bit value to send; a read-only register returns the value fetched from the PHY; a control/status register carries a bus enable and a combined start/busy bit.

Writing the control register with both the enable and the start bit set launches one frame. The start bit then reads back as 1 until the last bit of the frame has been clocked, and software polls it before touching the other registers. The block makes the management clock by dividing the system clock, shifts the frame out MSB first, releases the data line for the turnaround and data of a read, and stores the sampled value.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset the management clock is low, the output enable is low, and all four registers read 0.
- R2: Byte offsets decode as 0x7E4 address, 0x7E8 write data, 0x7EC read data, 0x7F0 control. The address register holds the PHY register number in bits 4:0, the PHY address in bits 9:5 and the direction in bit 10 (1 = read, 0 = write); the write data register holds bits 15:0; unused bits read 0.
- R3: A control write with bit 0 = 1 and bit 3 = 1 while idle starts a frame; the control register reads back bit 3 as the stored enable and bit 0 as 1 from the next cycle until the frame ends.
- R4: A control write with bit 0 = 1 but bit 3 = 0 starts nothing: the clock stays low and bit 0 reads 0.
- R5: While bit 0 reads 1, bus writes to every register are ignored, including a second start.
- R6: The management clock has a period of 2*DIV_HALF system clocks while a frame runs and is low when idle; the data line changes only after its falling edge and is sampled at its rising edge.
- R7: A write frame is 64 bits MSB first: 32 ones, 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, 16 data bits, with output enable high throughout.
- R8: A read frame carries opcode 10; output enable is low from bit 46 (first turnaround bit) through bit 63; the 16 bits sampled in bits 48..63 appear in the read data register when bit 0 clears.
- R9: A write frame leaves the read data register unchanged, and bus writes to the read data register have no effect.
- R10: Each frame has exactly 64 clock pulses; after it the clock is low, output enable is low and bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input value |

## Verification
Register effects are due one system clock after the write strobe, so the bench reads busy and the stored fields at the falling edge after the write. Frame bits are due at each rising management-clock edge, where the bench's PHY model records line value and enable, and it presents response bits after each falling edge so they are stable for half a period before the master samples them. The read result and the end of the frame are due only when bit 0 clears, which the bench finds by polling the control register rather than by counting cycles.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int OFS_ADDR   = 'h7E4;
  localparam int OFS_WDATA  = 'h7E8;
  localparam int OFS_RDATA  = 'h7EC;
  localparam int OFS_CTRL   = 'h7F0;
  localparam int BIT_GO     = 0;
  localparam int BIT_EN     = 3;
  localparam int BIT_OP     = 10;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic done;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output mdioStrobe_t strb,
  output logic        busy,
  output logic        mdc,
  output logic        respWindow
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             tick;

  always_comb begin
    tick        = busy && (divCnt == CNT_TOP);
    strb.load   = startReq && !busy;
    strb.sample = tick && !mdc;
    strb.shift  = tick && mdc && (bitIdx != LAST_IDX);
    strb.done   = tick && mdc && (bitIdx == LAST_IDX);
    respWindow  = bitIdx >= IDX_W'(TA_FIRST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= !mdc;
        if (strb.shift) bitIdx <= bitIdx + 1'b1;
        if (strb.done)  busy   <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R6: clock rests low whenever no frame runs
  assert_mdc_low_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R6: at most one engine action per system cycle
  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.sample, strb.shift, strb.done}));
  // R10: frame end leaves clock low and engine idle
  assert_frame_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> (!busy && !mdc));
  // R5: a start request during a frame does not restart the bit counter
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !strb.done && bitIdx != '0) |=> (bitIdx != '0));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  mdioStrobe_t       strb,
  input  logic              busy,
  input  logic              respWindow,
  output logic              startReq,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic [BIT_OP:0]       addrReg;
  logic [15:0]           wrReg;
  logic [15:0]           rdReg;
  logic                  enReg;
  logic [FRAME_BITS-1:0] txShift;
  logic [15:0]           rxShift;
  logic                  opRead;
  logic selAddr, selWdata, selRdata, selCtrl;
  logic [FRAME_BITS-1:0] frameWord;

  always_comb begin
    selAddr  = busAddr == ADDR_W'(OFS_ADDR);
    selWdata = busAddr == ADDR_W'(OFS_WDATA);
    selRdata = busAddr == ADDR_W'(OFS_RDATA);
    selCtrl  = busAddr == ADDR_W'(OFS_CTRL);
    startReq = busWe && selCtrl && busWdata[BIT_GO] && busWdata[BIT_EN];
    frameWord = {32'hFFFF_FFFF, 2'b01,
                 addrReg[BIT_OP] ? 2'b10 : 2'b01,
                 addrReg[9:5], addrReg[4:0],
                 addrReg[BIT_OP] ? 2'b11 : 2'b10,
                 addrReg[BIT_OP] ? 16'hFFFF : wrReg};
    mdioOe  = busy && !(opRead && respWindow);
    mdioOut = mdioOe && txShift[FRAME_BITS-1];
    busRdata = '0;
    if (selAddr)  busRdata[BIT_OP:0] = addrReg;
    if (selWdata) busRdata[15:0]     = wrReg;
    if (selRdata) busRdata[15:0]     = rdReg;
    if (selCtrl) begin
      busRdata[BIT_EN] = enReg;
      busRdata[BIT_GO] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdReg   <= '0;
      enReg   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      opRead  <= 1'b0;
    end else begin
      if (busWe && !busy) begin
        if (selAddr)  addrReg <= busWdata[BIT_OP:0];
        if (selWdata) wrReg   <= busWdata[15:0];
        if (selCtrl)  enReg   <= busWdata[BIT_EN];
      end
      if (strb.load) begin
        txShift <= frameWord;
        opRead  <= addrReg[BIT_OP];
      end else if (strb.shift) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.sample) rxShift <= {rxShift[14:0], mdioIn};
      if (strb.done && opRead) rdReg <= rxShift;
    end
  end

  // R5: fields are frozen while a frame runs
  assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrReg));
  assert_wdata_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wrReg));
  // R8: line released during a read response
  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opRead && respWindow) |-> !mdioOe);
  // R9: read data only moves at the end of a read frame
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.done && opRead) |=> $stable(rdReg));
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DIV_HALF = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrobe_t strb;
  logic busy, respWindow, startReq;

  mdio_ctrl #(.DIV_HALF(DIV_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strb(strb),
    .busy(busy), .mdc(mdc), .respWindow(respWindow)
  );

  mdio_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .strb(strb), .busy(busy),
    .respWindow(respWindow), .startReq(startReq), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: tb/tb_mdio_mgmt_top.sv
module tb_mdio_mgmt_top;
  localparam int ADDR_W = 12;
  localparam int DIV_HALF = 10;
  localparam longint PERIOD_NS = 20 * 2 * DIV_HALF;
  localparam logic [ADDR_W-1:0] A_ADDR = 12'h7E4, A_WD = 12'h7E8,
                                A_RD = 12'h7EC, A_CTRL = 12'h7F0;

  logic clk = 0, rstN = 0, busWe = 0, mdioIn = 1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic mdc, mdioOut, mdioOe;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  int phyBit = 0, riseCount = 0;
  logic [63:0] capBits, capOe;
  logic [15:0] phyVal = '0;
  longint lastRise = -1;
  bit perBad = 0;

  always #10 clk = ~clk;

  mdio_mgmt_top #(.ADDR_W(ADDR_W), .DIV_HALF(DIV_HALF)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  // PHY model: records each bit at the rising edge, answers after falling edge
  always @(posedge mdc) begin
    if (phyBit < 64) begin
      capBits[63-phyBit] = mdioOut;
      capOe[63-phyBit]   = mdioOe;
    end
    phyBit++;
    riseCount++;
    if (lastRise >= 0 && (longint'($time) - lastRise) != PERIOD_NS) perBad = 1;
    lastRise = longint'($time);
  end
  always @(negedge mdc)
    mdioIn = (phyBit >= 48 && phyBit < 64) ? phyVal[63-phyBit] : 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #2 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      busRead(A_CTRL, v);
      if (v[0] == 1'b0) return;
    end
  endtask

  function automatic logic [63:0] buildFrame(bit rd, logic [4:0] phy,
                                             logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
            rd ? 2'b00 : 2'b10, rd ? 16'h0 : d};
  endfunction

  task automatic runTxn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, input logic [15:0] resp,
                        input bit midWrites);
    logic [31:0] v, rdBefore;
    logic [63:0] exp;
    busRead(A_RD, rdBefore);
    busWrite(A_ADDR, {21'h0, rd, phy, rg});
    busWrite(A_WD, {16'hABCD, d});
    phyBit = 0; riseCount = 0; lastRise = -1; perBad = 0; phyVal = resp;
    busWrite(A_CTRL, 32'h9);
    busRead(A_CTRL, v);
    check(v[3:0] == 4'h9, "R3", "busy+enable after start", 64'(v), 64'h9);
    if (midWrites) begin
      repeat (300) @(negedge clk);
      busWrite(A_ADDR, 32'h7FF);
      busWrite(A_WD, 32'h5A5A);
      busWrite(A_RD, 32'h1234);
      busWrite(A_CTRL, 32'h9);
      busWrite(A_CTRL, 32'h0);
      busRead(A_CTRL, v);
      check(v[3:0] == 4'h9, "R5", "control ignored while busy", 64'(v), 64'h9);
    end
    waitIdle();
    repeat (3 * DIV_HALF) @(negedge clk);
    exp = buildFrame(rd, phy, rg, d);
    check(riseCount == 64, "R10", "clock pulses per frame", 64'(riseCount), 64'd64);
    check(!mdc && !mdioOe, "R10", "clock/oe low after frame",
          64'({mdc, mdioOe}), 64'h0);
    check(!perBad, "R6", "clock period", 64'(perBad), 64'h0);
    if (rd) begin
      check(capBits[63:18] == exp[63:18], "R8", "read frame header",
            64'(capBits[63:18]), 64'(exp[63:18]));
      check(capOe == {{46{1'b1}}, 18'h0}, "R8", "read oe pattern", capOe,
            {{46{1'b1}}, 18'h0});
      busRead(A_RD, v);
      check(v == {16'h0, resp}, "R8", "read data", 64'(v), 64'(resp));
    end else begin
      check(capBits == exp, "R7", "write frame", capBits, exp);
      check(capOe == '1, "R7", "write oe", capOe, '1);
      busRead(A_RD, v);
      check(v == rdBefore, "R9", "read data kept by write", 64'(v), 64'(rdBefore));
    end
    if (midWrites) begin
      busRead(A_ADDR, v);
      check(v == {21'h0, rd, phy, rg}, "R5", "address kept", 64'(v),
            64'({21'h0, rd, phy, rg}));
      busRead(A_WD, v);
      check(v == {16'h0, d}, "R5", "write data kept", 64'(v), 64'(d));
    end
  endtask

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!mdc && !mdioOe, "R1", "pins after reset", 64'({mdc, mdioOe}), 64'h0);
    busRead(A_ADDR, v); check(v == 0, "R1", "addr reg reset", 64'(v), 64'h0);
    busRead(A_WD, v);   check(v == 0, "R1", "wdata reg reset", 64'(v), 64'h0);
    busRead(A_RD, v);   check(v == 0, "R1", "rdata reg reset", 64'(v), 64'h0);
    busRead(A_CTRL, v); check(v == 0, "R1", "ctrl reg reset", 64'(v), 64'h0);
    // R2 field widths
    busWrite(A_ADDR, 32'hFFFF_FFFF);
    busRead(A_ADDR, v); check(v == 32'h7FF, "R2", "addr field mask", 64'(v), 64'h7FF);
    busWrite(A_WD, 32'hFFFF_FFFF);
    busRead(A_WD, v); check(v == 32'hFFFF, "R2", "wdata field mask", 64'(v), 64'hFFFF);
    // R9 read data ignores bus writes
    busWrite(A_RD, 32'hBEEF);
    busRead(A_RD, v); check(v == 0, "R9", "rdata not writable", 64'(v), 64'h0);
    // R4 start without enable
    riseCount = 0;
    busWrite(A_CTRL, 32'h1);
    repeat (4 * DIV_HALF) @(negedge clk);
    busRead(A_CTRL, v);
    check(v == 0, "R4", "no busy without enable", 64'(v), 64'h0);
    check(riseCount == 0, "R4", "no clock without enable", 64'(riseCount), 64'h0);
    // directed frames
    runTxn(0, 5'h1F, 5'h00, 16'hFFFF, 16'h0, 0);
    runTxn(1, 5'h00, 5'h1F, 16'h0, 16'h8001, 0);
    runTxn(0, 5'h0A, 5'h15, 16'h1234, 16'h0, 1);
    runTxn(1, 5'h03, 5'h02, 16'h0, 16'hA5C3, 1);
    // random frames
    for (int k = 0; k < 10; k++) begin
      runTxn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
             16'($urandom), 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule